// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block holds the divider configuration of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test-select code. Software-free board logic sets these values in one of two ways. A parallel path takes them from pins, following the pins while an active-low strobe is low and freezing them when the strobe rises. A serial path shifts a 14-bit frame in over a three-wire link (shift clock, data and load) and commits it on the load line.

All three serial wires and the parallel strobe are slow, asynchronous signals. Each is brought through a two-stage synchronizer into the system clock domain, and edges are found on the synchronized copies, so the system clock must run at least four times faster than the serial shift clock. The block also selects what appears on a test pin. It flags a held feedback value that lies outside the lockable range, and it raises a one-cycle strobe whenever the held configuration changes.

Top module: `divcfg_loader`

## Requirements
- R1: After reset the held configuration is feedback value 20, output code 00 and test code 00, and `test_out` is low.
- R2: While `par_load_n` is low, `m_val` and `n_code` follow `par_m` and `par_n`, `t_sel` keeps its value, and `test_out` is low.
- R3: When `par_load_n` rises, the last pin values are held, and later changes on `par_m` and `par_n` have no effect on the outputs.
- R4: With `par_load_n` high and `ser_load` low, each rising edge of `ser_clk` shifts `ser_data` into a 14-bit register, and the outputs do not change. The frame is sent in this order: T1, T0, one unused slot, N1, N0, then M8 down to M0.
- R5: A rising edge of `ser_load` copies the frame to the outputs: bits 13:12 go to `t_sel`, bits 10:9 go to `n_code` and bits 8:0 go to `m_val`, where bit 0 is the last bit shifted. The values stay held after `ser_load` falls and while further bits are shifted.
- R6: While `ser_load` stays high, every rising edge of `ser_clk` shifts the register and updates the outputs at once, so `m_val[0]` equals the bit just shifted in.
- R7: With `par_load_n` high, `test_out` is chosen by `t_sel`: code 00 gives low, 01 gives the synchronized serial data input, 10 gives `mdiv_fb` and 11 gives `synth_clk`.
- R8: `out_of_range` is high exactly when `m_val` is below 10 or above 28.
- R9: `cfg_valid` is high for one system clock in the cycle in which any of `m_val`, `n_code` or `t_sel` takes a new value, and low in every other cycle.
- R10: A new low phase of `par_load_n` after a serial load replaces `m_val` and `n_code` with the pin values and keeps `t_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| par_load_n | input | 1 | Parallel strobe, active low, asynchronous |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load line |
| mdiv_fb | input | 1 | Feedback divider output, routed to test pin |
| synth_clk | input | 1 | Synthesized clock, routed to test pin |
| m_val | output | 9 | Held feedback divide value |
| n_code | output | 2 | Held output divide code |
| t_sel | output | 2 | Held test-select code |
| test_out | output | 1 | Test pin |
| out_of_range | output | 1 | Held feedback value outside 10..28 |
| cfg_valid | output | 1 | One-cycle strobe when the configuration changes |

## Verification
Several checks run on every cycle. The assertions cover the transparent parallel path and the forced-low test pin while the strobe is low. They check that plain shifting never moves the held values, and that `cfg_valid` matches a real change of the configuration in both directions. The frame bit order, the two-phase commit on the load line, the pass-through mode, the four test-pin sources and the range flag at 9, 10, 28 and 29 depend on sequences of slow pin events, so only the directed scenarios of the bench can show them.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int SPARE_W = 1;
  localparam int FRAME_W = T_W + SPARE_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TSRC_LOW  = 2'b00,
    TSRC_SDIN = 2'b01,
    TSRC_MDIV = 2'b10,
    TSRC_FOUT = 2'b11
  } tsrc_e;

  function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
    cfg_t c;
    c.m = f[M_W-1:0];
    c.n = f[M_W+N_W-1:M_W];
    c.t = f[FRAME_W-1:FRAME_W-T_W];
    return c;
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL[b]}};
      else        stg_q <= {stg_q[STAGES-2:0], d[b]};
    end
    assign q[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg
  import divcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sr_q,
  output logic [FRAME_W-1:0] sr_d
);
  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold
  import divcfg_pkg::*;
#(
  parameter cfg_t DEF_CFG = '{t: 2'b00, n: 2'b00, m: 9'd20}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic par_open,
  input  logic ser_commit,
  input  logic ser_pass,
  input  cfg_t par_cfg,
  input  cfg_t ser_cfg,
  input  cfg_t pass_cfg,
  output cfg_t cfg_q,
  output logic valid_q
);
  cfg_t cfg_d;
  logic valid_d;

  always_comb begin
    cfg_d = cfg_q;
    if (par_open) begin
      cfg_d.m = par_cfg.m;
      cfg_d.n = par_cfg.n;
    end else if (ser_commit) begin
      cfg_d = ser_cfg;
    end else if (ser_pass) begin
      cfg_d = pass_cfg;
    end
    valid_d = (cfg_d != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= DEF_CFG;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int M_LO = 10,
  parameter int M_HI = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           mdiv_fb,
  input  logic           synth_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           test_out,
  output logic           out_of_range,
  output logic           cfg_valid
);
  localparam logic [M_W-1:0] M_LO_V = M_W'(M_LO);
  localparam logic [M_W-1:0] M_HI_V = M_W'(M_HI);
  localparam int             NSYNC  = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i_n = rst_sh[1];

  // pin synchronizers: {strobe, load, data, sclk}; strobe idles high
  logic [NSYNC-1:0] pins_s;
  logic pl_s, sl_s, sd_s, sc_s;
  divcfg_sync #(.W(NSYNC), .STAGES(2), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({par_load_n, ser_load, ser_data, ser_clk}),
    .q     (pins_s)
  );
  assign {pl_s, sl_s, sd_s, sc_s} = pins_s;

  // edge detection on synchronized copies
  logic sc_d, sl_d;
  logic sc_rise, sl_rise;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sc_d <= 1'b0;
      sl_d <= 1'b0;
    end else begin
      sc_d <= sc_s;
      sl_d <= sl_s;
    end
  end
  assign sc_rise = sc_s & ~sc_d;
  assign sl_rise = sl_s & ~sl_d;

  // serial shift register
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               shift_en;
  assign shift_en = pl_s & sc_rise;
  divcfg_shreg u_shreg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (shift_en),
    .din      (sd_s),
    .sr_q     (sr_q),
    .sr_d     (sr_d)
  );

  // held configuration
  cfg_t par_cfg, cfg_q;
  assign par_cfg = '{t: '0, n: par_n, m: par_m};
  divcfg_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .par_open   (~pl_s),
    .ser_commit (pl_s & sl_rise),
    .ser_pass   (pl_s & sl_s & sc_rise),
    .par_cfg    (par_cfg),
    .ser_cfg    (frame_to_cfg(sr_q)),
    .pass_cfg   (frame_to_cfg(sr_d)),
    .cfg_q      (cfg_q),
    .valid_q    (cfg_valid)
  );

  assign m_val  = cfg_q.m;
  assign n_code = cfg_q.n;
  assign t_sel  = cfg_q.t;

  // test pin source select
  always_comb begin
    test_out = 1'b0;
    if (pl_s) begin
      case (tsrc_e'(cfg_q.t))
        TSRC_LOW:  test_out = 1'b0;
        TSRC_SDIN: test_out = sd_s;
        TSRC_MDIV: test_out = mdiv_fb;
        TSRC_FOUT: test_out = synth_clk;
        default:   test_out = 1'b0;
      endcase
    end
  end

  assign out_of_range = (cfg_q.m < M_LO_V) || (cfg_q.m > M_HI_V);
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk (
  input logic       clk,
  input logic       rst_i_n,
  input logic       pl_s,
  input logic       sl_s,
  input logic [8:0] par_m,
  input logic [8:0] m_val,
  input logic [1:0] n_code,
  input logic [1:0] t_sel,
  input logic       test_out,
  input logic       cfg_valid
);
  AST_PAR_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pl_s |=> (m_val == $past(par_m))); // R2

  AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pl_s |-> !test_out); // R2

  AST_SHIFT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pl_s && !sl_s) |=> ($stable(m_val) && $stable(n_code) && $stable(t_sel))); // R4

  AST_VALID_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !($stable(m_val) && $stable(n_code) && $stable(t_sel)) |-> cfg_valid); // R9

  AST_VALID_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_valid |-> !($stable(m_val) && $stable(n_code) && $stable(t_sel))); // R9
endmodule

bind divcfg_loader divcfg_loader_chk u_chk (
  .clk       (clk),
  .rst_i_n   (rst_i_n),
  .pl_s      (pl_s),
  .sl_s      (sl_s),
  .par_m     (par_m),
  .m_val     (m_val),
  .n_code    (n_code),
  .t_sel     (t_sel),
  .test_out  (test_out),
  .cfg_valid (cfg_valid)
);

// File: tb/divcfg_loader_tb.sv
module divcfg_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n, ser_clk, ser_data, ser_load, mdiv_fb, synth_clk;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] m_val;
  logic [1:0] n_code, t_sel;
  logic       test_out, out_of_range, cfg_valid;

  int total = 0;
  int bad   = 0;
  int vcount = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  divcfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load), .mdiv_fb(mdiv_fb),
    .synth_clk(synth_clk), .m_val(m_val), .n_code(n_code), .t_sel(t_sel),
    .test_out(test_out), .out_of_range(out_of_range), .cfg_valid(cfg_valid)
  );

  always @(negedge clk) begin
    if (cfg_valid) vcount++;
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [13:0] mk(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    return {t, 1'b0, n, m};
  endfunction

  task automatic shift_bit(input logic b);
    ser_data = b; wait_n(4);
    ser_clk = 1'b1; wait_n(4);
    ser_clk = 1'b0; wait_n(4);
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; wait_n(6);
    ser_load = 1'b0; wait_n(6);
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    par_m = m; par_n = n;
    par_load_n = 1'b0; wait_n(6);
    par_load_n = 1'b1; wait_n(6);
  endtask

  task automatic t_reset();
    chk("R1 m during reset", m_val, 20);
    chk("R1 n during reset", n_code, 0);
    chk("R1 t during reset", t_sel, 0);
    rst_n = 1'b1; wait_n(8);
    chk("R1 m after reset", m_val, 20);
    chk("R1 test_out after reset", test_out, 0);
    chk("R9 no valid after reset", vcount, 0);
  endtask

  task automatic t_parallel();
    par_m = 9'd25; par_n = 2'd2;
    par_load_n = 1'b0; wait_n(6);
    chk("R2 m follows pins", m_val, 25);
    chk("R2 n follows pins", n_code, 2);
    chk("R2 test low", test_out, 0);
    par_m = 9'd12; wait_n(4);
    chk("R2 m follows change", m_val, 12);
    par_load_n = 1'b1; wait_n(6);
    par_m = 9'd99; par_n = 2'd1; wait_n(6);
    chk("R3 m held", m_val, 12);
    chk("R3 n held", n_code, 2);
  endtask

  task automatic t_serial();
    shift_frame(mk(2'b01, 2'b11, 9'd27));
    chk("R4 m unchanged by shift", m_val, 12);
    chk("R4 t unchanged by shift", t_sel, 0);
    vcount = 0;
    ser_load = 1'b1; wait_n(6);
    chk("R5 m on load rise", m_val, 27);
    chk("R5 n on load rise", n_code, 3);
    chk("R5 t on load rise", t_sel, 1);
    ser_load = 1'b0; wait_n(6);
    chk("R9 one valid pulse", vcount, 1);
    vcount = 0;
    shift_frame(mk(2'b10, 2'b00, 9'd300));
    chk("R5 m held after fall", m_val, 27);
    chk("R5 t held after fall", t_sel, 1);
    chk("R9 no pulse on shift", vcount, 0);
    pulse_load();
    chk("R5 second frame m", m_val, 300);
    chk("R5 second frame t", t_sel, 2);
  endtask

  task automatic t_testmux();
    mdiv_fb = 1'b1; wait_n(2);
    chk("R7 code10 mdiv high", test_out, 1);
    mdiv_fb = 1'b0; wait_n(2);
    chk("R7 code10 mdiv low", test_out, 0);
    shift_frame(mk(2'b01, 2'b00, 9'd20)); pulse_load();
    ser_data = 1'b1; wait_n(4);
    chk("R7 code01 data high", test_out, 1);
    ser_data = 1'b0; wait_n(4);
    chk("R7 code01 data low", test_out, 0);
    shift_frame(mk(2'b11, 2'b00, 9'd20)); pulse_load();
    synth_clk = 1'b1; wait_n(2);
    chk("R7 code11 fout high", test_out, 1);
    synth_clk = 1'b0; wait_n(2);
    chk("R7 code11 fout low", test_out, 0);
    synth_clk = 1'b1;
    par_load_n = 1'b0; wait_n(6);
    chk("R2 test forced low in parallel", test_out, 0);
    par_load_n = 1'b1; wait_n(6);
    chk("R10 t kept through parallel", t_sel, 3);
    chk("R10 m replaced by pins", m_val, 99);
    chk("R10 n replaced by pins", n_code, 1);
    synth_clk = 1'b0;
    shift_frame(mk(2'b00, 2'b00, 9'd20)); pulse_load();
    mdiv_fb = 1'b1; ser_data = 1'b1; wait_n(4);
    chk("R7 code00 low", test_out, 0);
    mdiv_fb = 1'b0; ser_data = 1'b0;
  endtask

  task automatic t_pass();
    ser_load = 1'b1; wait_n(6);
    shift_bit(1'b1);
    chk("R6 bit0 passes", m_val[0], 1);
    shift_bit(1'b0);
    chk("R6 bit1 passes", m_val[0], 0);
    shift_bit(1'b1);
    chk("R6 pattern 101", m_val[2:0], 5);
    chk("R6 upper shifted", m_val[8:3], 6'd20);
    ser_load = 1'b0; wait_n(6);
    chk("R6 held after release", m_val, 9'd165);
  endtask

  task automatic t_range();
    par_load(9'd9, 2'd0);
    chk("R8 m=9 out", out_of_range, 1);
    par_load(9'd10, 2'd0);
    chk("R8 m=10 in", out_of_range, 0);
    par_load(9'd28, 2'd0);
    chk("R8 m=28 in", out_of_range, 0);
    par_load(9'd29, 2'd0);
    chk("R8 m=29 out", out_of_range, 1);
    vcount = 0;
    par_load(9'd29, 2'd0);
    chk("R9 no pulse on same value", vcount, 0);
  endtask

  initial begin
    rst_n = 1'b0; par_load_n = 1'b1; par_m = '0; par_n = '0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    mdiv_fb = 1'b0; synth_clk = 1'b0;
    wait_n(4);
    t_reset();
    t_parallel();
    t_serial();
    t_testmux();
    t_pass();
    t_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule